// File: doc/BRIEF.md
# Converter Result Buffer Readout

This block keeps a bank of signed conversion results in 25 slots. A converter-side write port puts a 14-bit two's-complement result into any slot. The host side sees a small register set: a 5-bit read index, a one-bit alignment setting, and a 16-bit data word that is read with a strobe. Each read returns the slot that the index points to, formatted by the alignment setting, and then moves the index on by one. Repeated strobes therefore walk through the bank without the host reloading the index.

The host cannot write the slots. Only the converter port changes them, and every slot clears to zero on reset. The returned word is registered. A small state machine has two states, `RD_IDLE` (no fresh word) and `RD_SHOW` (fresh word on the port). A strobe takes either state to `RD_SHOW` on the next edge (transition `T_READ`). A cycle without a strobe takes either state to `RD_IDLE` (transition `T_DROP`). Temperature and voltage results are formatted the same way.

Top module: `conv_result_bank`

## Requirements
- R1: After reset, every slot holds zero, the index is 0, alignment is 0 (right), and `rd_valid` is low.
- R2: A `host_rd` strobe sampled at edge N drives `rd_valid` high in the cycle after edge N, carrying that read's word. `rd_valid` is low in any cycle whose preceding edge saw no strobe. `rd_data` holds its last word until the next read.
- R3: Each read that has no index write in the same cycle advances the index by one, so back-to-back reads return consecutive slots.
- R4: A read at index 24 wraps the index to 0. A read at any index from 25 to 31 returns 0x0000 and sets the index to 0.
- R5: If an index write and a read occur in the same cycle, the index takes the written value. The returned word comes from the index held before that edge.
- R6: With alignment 1, `rd_data[15:2]` holds the 14-bit result and `rd_data[1:0]` is 0.
- R7: With alignment 0, `rd_data[13:0]` holds the result and `rd_data[15:14]` are both copies of result bit 13.
- R8: A converter write with slot 0..24 stores its data in that slot. A converter write with slot 25..31 changes no slot.
- R9: If a converter write and a read hit the same slot in the same cycle, the read returns the old value. The new value is returned by any later read of that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cv_wr_en | input | 1 | Converter store strobe |
| cv_wr_slot | input | 5 | Slot number to store into |
| cv_wr_data | input | 14 | Two's-complement result to store |
| host_idx_wr | input | 1 | Host write of the read index |
| host_idx_wdata | input | 5 | New read index value |
| host_cfg_wr | input | 1 | Host write of the alignment setting |
| host_cfg_align | input | 1 | 1 = left aligned, 0 = right aligned |
| host_rd | input | 1 | Data word read strobe |
| rd_data | output | 16 | Formatted result word |
| rd_valid | output | 1 | High in the cycle that follows a read strobe |
| idx_q | output | 5 | Current read index |
| align_q | output | 1 | Current alignment setting |

## Verification
A read word and its `rd_valid` appear one edge after the strobe. A new index or alignment value shows on `idx_q` and `align_q` after the same edge. A converter store becomes readable from the next cycle. The bench drives every input at a falling edge and samples at the next falling edge, so each check sees exactly one rising edge after its stimulus. Expected words come from a per-slot model in the bench, which applies signed arithmetic for right alignment and multiplies by four for left alignment. The sweeps cover all 25 slots, the out-of-range indices and both alignments, including reads held high across many consecutive cycles.

// File: rtl/crb_pkg.sv
package crb_pkg;
    localparam int SLOT_COUNT = 25;
    localparam int RESULT_W   = 14;
    localparam int WORD_W     = 16;
    localparam int INDEX_W    = $clog2(SLOT_COUNT);

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_SHOW = 1'b1
    } rd_state_e;
endpackage

// File: rtl/crb_slot_store.sv
module crb_slot_store #(
    parameter int SLOTS = 25,
    parameter int RES_W = 14,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_slot,
    input  logic [RES_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_slot,
    output logic [RES_W-1:0] rd_result
);
    logic [RES_W-1:0] slot_q [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (wr_slot == IDX_W'(i)) slot_q[i] <= wr_data;
            end
        end
    end

    // Out-of-range index selects nothing and reads as zero.
    always_comb begin
        rd_result = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (rd_slot == IDX_W'(i)) rd_result = slot_q[i];
        end
    end

    // R8
    store_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_slot < IDX_W'(SLOTS)) && (rd_slot == wr_slot))
        |=> (slot_q[$past(wr_slot)] == $past(wr_data)));
endmodule

// File: rtl/crb_index_ctl.sv
module crb_index_ctl #(
    parameter int SLOTS = 25,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_rd,
    input  logic             idx_wr,
    input  logic [IDX_W-1:0] idx_wdata,
    input  logic             cfg_wr,
    input  logic             cfg_align,
    output logic [IDX_W-1:0] idx_q,
    output logic             align_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

    logic [IDX_W-1:0] idx_step;

    always_comb begin
        if (idx_q >= LAST_IDX) idx_step = '0;
        else                   idx_step = idx_q + IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       idx_q <= '0;
        else if (idx_wr)  idx_q <= idx_wdata;
        else if (host_rd) idx_q <= idx_step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      align_q <= 1'b0;
        else if (cfg_wr) align_q <= cfg_align;
    end

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !idx_wr && (idx_q < LAST_IDX)) |=> (idx_q == $past(idx_q) + IDX_W'(1)));
    // R4
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !idx_wr && (idx_q >= LAST_IDX)) |=> (idx_q == '0));
    // R5
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (idx_q == $past(idx_wdata)));
    // R3
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_wr && !host_rd) |=> $stable(idx_q));
endmodule

// File: rtl/crb_align_fmt.sv
module crb_align_fmt #(
    parameter int RES_W  = 14,
    parameter int WORD_W = 16
) (
    input  logic [RES_W-1:0]  result,
    input  logic              align_left,
    output logic [WORD_W-1:0] word
);
    localparam int PAD_W = WORD_W - RES_W;

    always_comb begin
        if (align_left) word = {result, {PAD_W{1'b0}}};
        else            word = {{PAD_W{result[RES_W-1]}}, result};
    end
endmodule

// File: rtl/crb_read_fsm.sv
module crb_read_fsm
    import crb_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);
    rd_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            RD_IDLE: state_d = host_rd ? RD_SHOW : RD_IDLE;  // T_READ / T_DROP
            RD_SHOW: state_d = host_rd ? RD_SHOW : RD_IDLE;  // T_READ / T_DROP
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_data <= '0;
        else if (host_rd) rd_data <= word_in;
    end

    always_comb rd_valid = (state_q == RD_SHOW);

    // R2
    rd_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> rd_valid);
    // R2
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> (!rd_valid && $stable(rd_data)));
endmodule

// File: rtl/conv_result_bank.sv
module conv_result_bank
    import crb_pkg::*;
#(
    parameter int SLOTS  = SLOT_COUNT,
    parameter int RES_W  = RESULT_W,
    parameter int WORD_W = crb_pkg::WORD_W,
    parameter int IDX_W  = INDEX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cv_wr_en,
    input  logic [IDX_W-1:0]  cv_wr_slot,
    input  logic [RES_W-1:0]  cv_wr_data,
    input  logic              host_idx_wr,
    input  logic [IDX_W-1:0]  host_idx_wdata,
    input  logic              host_cfg_wr,
    input  logic              host_cfg_align,
    input  logic              host_rd,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [IDX_W-1:0]  idx_q,
    output logic              align_q
);
    logic [RES_W-1:0]  sel_result;
    logic [WORD_W-1:0] fmt_word;

    crb_slot_store #(.SLOTS(SLOTS), .RES_W(RES_W), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cv_wr_en), .wr_slot(cv_wr_slot), .wr_data(cv_wr_data),
        .rd_slot(idx_q), .rd_result(sel_result)
    );

    crb_index_ctl #(.SLOTS(SLOTS), .IDX_W(IDX_W)) index_i (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd),
        .idx_wr(host_idx_wr), .idx_wdata(host_idx_wdata),
        .cfg_wr(host_cfg_wr), .cfg_align(host_cfg_align),
        .idx_q(idx_q), .align_q(align_q)
    );

    crb_align_fmt #(.RES_W(RES_W), .WORD_W(WORD_W)) fmt_i (
        .result(sel_result), .align_left(align_q), .word(fmt_word)
    );

    crb_read_fsm #(.WORD_W(WORD_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd),
        .word_in(fmt_word), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // R6
    left_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && align_q) |=> (rd_data[1:0] == 2'b00));
    // R7
    right_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !align_q) |=> (rd_data[WORD_W-1:RES_W] == {(WORD_W-RES_W){rd_data[RES_W-1]}}));
    // R4
    beyond_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (idx_q >= IDX_W'(SLOTS))) |=> (rd_data == '0));
endmodule

// File: tb/conv_result_bank_tb_top.sv
module conv_result_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cv_wr_en = 1'b0;
    logic [4:0]  cv_wr_slot = '0;
    logic [13:0] cv_wr_data = '0;
    logic        host_idx_wr = 1'b0;
    logic [4:0]  host_idx_wdata = '0;
    logic        host_cfg_wr = 1'b0;
    logic        host_cfg_align = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic [4:0]  idx_q;
    logic        align_q;

    int n_cmp = 0;
    int n_bad = 0;
    int slot_m [25];
    int idx_m = 0;
    int align_m = 0;
    bit done = 0;

    always #4 clk = ~clk;

    conv_result_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .cv_wr_en(cv_wr_en), .cv_wr_slot(cv_wr_slot), .cv_wr_data(cv_wr_data),
        .host_idx_wr(host_idx_wr), .host_idx_wdata(host_idx_wdata),
        .host_cfg_wr(host_cfg_wr), .host_cfg_align(host_cfg_align),
        .host_rd(host_rd), .rd_data(rd_data), .rd_valid(rd_valid),
        .idx_q(idx_q), .align_q(align_q)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int fmt_exp(int idx, int al);
        int v;
        if (idx > 24) return 0;
        v = slot_m[idx];
        if (al != 0) return (v * 4) % 65536;
        if (v >= 8192) return 65536 + (v - 16384);
        return v;
    endfunction

    task automatic conv_write(int s, int v);
        cv_wr_en = 1'b1; cv_wr_slot = 5'(s); cv_wr_data = 14'(v);
        tick();
        cv_wr_en = 1'b0;
        if (s < 25) slot_m[s] = v;
    endtask

    task automatic set_idx(int i);
        host_idx_wr = 1'b1; host_idx_wdata = 5'(i);
        tick();
        host_idx_wr = 1'b0;
        idx_m = i;
    endtask

    task automatic set_align(int a);
        host_cfg_wr = 1'b1; host_cfg_align = a[0];
        tick();
        host_cfg_wr = 1'b0;
        align_m = a;
    endtask

    // Held strobe: each cycle reads the next slot (R2, R3).
    task automatic burst(string req, int n);
        for (int k = 0; k < n; k++) begin
            int e;
            e = fmt_exp(idx_m, align_m);
            host_rd = 1'b1;
            tick();
            idx_m = (idx_m >= 24) ? 0 : idx_m + 1;
            chk("R2 valid", int'(rd_valid), 1);
            chk(req, int'(rd_data), e);
            chk("R3 index", int'(idx_q), idx_m);
        end
        host_rd = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 25; i++) slot_m[i] = 0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 index", int'(idx_q), 0);
        chk("R1 align", int'(align_q), 0);
        chk("R1 valid", int'(rd_valid), 0);
        burst("R1 slots zero", 25);
        chk("R4 wrap after 24", int'(idx_q), 0);

        // R8: fill all slots with mixed-sign values
        for (int s = 0; s < 25; s++) conv_write(s, (s * 1237 + 5) % 16384);
        // R8: out-of-range writes touch nothing
        for (int s = 25; s < 32; s++) conv_write(s, 16383 - s);

        // R7 right alignment sweep with wrap, R3, R4
        set_idx(0);
        burst("R7 right word", 30);
        // R6 left alignment sweep
        set_align(1);
        chk("R6 align reg", int'(align_q), 1);
        set_idx(0);
        burst("R6 left word", 25);
        set_align(0);

        // R4: out-of-range indices read zero and wrap
        for (int i = 25; i < 32; i++) begin
            set_idx(i);
            host_rd = 1'b1;
            tick();
            host_rd = 1'b0;
            chk("R4 beyond zero", int'(rd_data), 0);
            chk("R4 beyond wrap", int'(idx_q), 0);
        end

        // R2: without strobe, no valid and data held
        set_idx(7);
        host_rd = 1'b1; tick(); host_rd = 1'b0;
        begin
            int held;
            held = fmt_exp(7, 0);
            chk("R2 data", int'(rd_data), held);
            tick();
            chk("R2 drop valid", int'(rd_valid), 0);
            chk("R2 data held", int'(rd_data), held);
            chk("R3 index hold", int'(idx_q), 8);
        end

        // R5: index write wins over increment; data from old index
        set_idx(5);
        host_rd = 1'b1; host_idx_wr = 1'b1; host_idx_wdata = 5'd20;
        tick();
        host_rd = 1'b0; host_idx_wr = 1'b0;
        chk("R5 old-index data", int'(rd_data), fmt_exp(5, 0));
        chk("R5 index loaded", int'(idx_q), 20);

        // R9: same-slot collision returns old, then new
        set_idx(3);
        begin
            int old_w;
            old_w = fmt_exp(3, 0);
            host_rd = 1'b1; cv_wr_en = 1'b1; cv_wr_slot = 5'd3; cv_wr_data = 14'h2ABC;
            tick();
            host_rd = 1'b0; cv_wr_en = 1'b0;
            slot_m[3] = 14'h2ABC;
            chk("R9 old value", int'(rd_data), old_w);
        end
        set_idx(3);
        host_rd = 1'b1; tick(); host_rd = 1'b0;
        chk("R9 new value", int'(rd_data), fmt_exp(3, 0));

        // R8: slots unchanged by out-of-range writes, final sweep
        set_idx(0);
        burst("R8 final contents", 25);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule